// File: doc/BRIEF.md
# Retention Latch Operand Cache

This block is a small, fully associative store of recently produced results for an out-of-order core whose reorder buffer has no ports for reading source operands. Each writeback presents a tag (the physical register or reorder slot of the result) and a data word. The block keeps the value only when the result is not short-lived, meaning its architectural destination has already been renamed again. No later consumer can read such a value from the latches, so filtering it out saves capacity for results that may still be looked up.

At issue, one or two lookup ports search all valid entries by tag and return hit and data in the same cycle. A miss tells the consumer to wait until the producer commits and the value appears on the ordinary result forwarding buses. The short-lived flag for a result arrives one cycle before that result's writeback and is registered inside the block. Replacement is either round-robin (FIFO) or least recently used, chosen by a parameter. A flush input empties the array for misprediction recovery.

Top module: `rl_operand_cache`

## Requirements
- R1: The array holds up to ENTRIES (2, 4, 8 or 16; default 8) distinct tags at once; after ENTRIES distinct accepted writes with no flush, every one of those tags hits.
- R2: A lookup port with its valid bit high reports hit and the stored data when a valid entry holds its tag, and reports miss with data zero otherwise; each of the RD_PORTS (1 or 2) ports works independently.
- R3: The short-lived flag sampled on a clock edge applies to the writeback presented in the cycle after that edge; a flag raised in the same cycle as a writeback does not affect that writeback.
- R4: A writeback whose short-lived flag is set writes no entry and leaves the replacement state unchanged, so later evictions are the same as if it had never occurred.
- R5: When an accepted write and a lookup carry the same tag in the same cycle, the lookup hits and returns the new data.
- R6: An accepted write whose tag is already stored updates that entry's data in place; it allocates no second entry and does not advance the FIFO position.
- R7: A flush clears every valid bit on the next clock edge and returns the FIFO position to slot 0; a writeback in the flush cycle is dropped and refreshes nothing.
- R8: Under FIFO (USE_LRU = 0), new tags fill slots in round-robin order, so the tag written ENTRIES allocations ago is the one evicted; lookups do not change the order.
- R9: Under LRU (USE_LRU = 1), a new tag takes the lowest-numbered empty slot, otherwise the least recently touched one; per cycle at most one entry is touched: the accepted write, else the port 0 hit, else the port 1 hit.
- R10: A lookup port whose valid bit is low reports miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the array on the next edge |
| wbSoonShort | input | 1 | Short-lived flag for the writeback of the following cycle |
| wbValid | input | 1 | A result is written back this cycle |
| wbTag | input | TAG_W | Tag of the written-back result |
| wbData | input | DATA_W | Written-back value |
| rdValid | input | RD_PORTS | Lookup request per port |
| rdTag | input | RD_PORTS*TAG_W | Lookup tags, port p in bits p*TAG_W upward |
| rdHit | output | RD_PORTS | Hit per port |
| rdData | output | RD_PORTS*DATA_W | Lookup data per port, zero on a miss |

## Verification
A corrupted valid bit or tag surfaces at a lookup port in the same cycle a consumer asks for that tag, as a miss that should hit or as stale data. A fault in the FIFO position or the LRU ages stays hidden until the array is full and one more new tag arrives; it then shows as the wrong survivor, so the bench overfills the array after short-lived writes, in-place updates and lookups, and looks up every tag. A wrong registered short-lived flag shows one cycle later as a stored value that should have been dropped, or a dropped value that should hit.

// File: rtl/rl_pkg.sv
package rl_pkg;
  // Widest entry index supported (16 entries)
  localparam int IDX_MAX_W = 4;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic                 wrEn;
    logic                 clrAll;
    logic [IDX_MAX_W-1:0] wrIdx;
  } rl_strobe_t;
endpackage

// File: rtl/rl_store.sv
module rl_store
  import rl_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int RD_PORTS = 2,
  parameter int TAG_W    = 6,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rl_strobe_t                   strobe,
  input  logic [TAG_W-1:0]             wrTag,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [RD_PORTS-1:0]          rdValid,
  input  logic [RD_PORTS*TAG_W-1:0]    rdTag,
  output logic [ENTRIES-1:0]           validVec,
  output logic [ENTRIES-1:0]           wrMatch,
  output logic [RD_PORTS*ENTRIES-1:0]  rdMatch,
  output logic [RD_PORTS-1:0]          rdHit,
  output logic [RD_PORTS*DATA_W-1:0]   rdData
);
  logic [TAG_W-1:0]  tagArr  [ENTRIES];
  logic [DATA_W-1:0] dataArr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              vld;
    logic [TAG_W-1:0]  tg;
    logic [DATA_W-1:0] dt;
    logic              sel;

    assign sel = strobe.wrEn && (strobe.wrIdx == IDX_MAX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              vld <= 1'b0;
      else if (strobe.clrAll) vld <= 1'b0;
      else if (sel)           vld <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tg <= wrTag;
        dt <= wrData;
      end
    end

    assign validVec[e] = vld;
    assign tagArr[e]   = tg;
    assign dataArr[e]  = dt;
    assign wrMatch[e]  = vld && (tg == wrTag);
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    logic [TAG_W-1:0]   qTag;
    logic [ENTRIES-1:0] match;
    logic [DATA_W-1:0]  picked;
    logic               bypass;

    assign qTag = rdTag[p*TAG_W +: TAG_W];

    always_comb begin
      picked = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        match[e] = rdValid[p] && validVec[e] && (tagArr[e] == qTag);
        if (match[e]) picked = picked | dataArr[e];
      end
    end

    assign bypass = strobe.wrEn && rdValid[p] && (qTag == wrTag);
    assign rdMatch[p*ENTRIES +: ENTRIES] = match;
    assign rdHit[p] = bypass || (|match);
    assign rdData[p*DATA_W +: DATA_W] = bypass ? wrData : picked;
  end
endmodule

// File: rtl/rl_ctrl.sv
module rl_ctrl
  import rl_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int RD_PORTS = 2,
  parameter int USE_LRU  = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        wbValid,
  input  logic                        wbSoonShort,
  input  logic [ENTRIES-1:0]          validVec,
  input  logic [ENTRIES-1:0]          wrMatch,
  input  logic [RD_PORTS*ENTRIES-1:0] rdMatch,
  output rl_strobe_t                  strobe
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [IDX_W-1:0] firstSet(input logic [ENTRIES-1:0] v);
    firstSet = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) firstSet = IDX_W'(i);
  endfunction

  logic             shortQ;
  logic             accept;
  logic             hitOld;
  logic [IDX_W-1:0] victimIdx;
  logic [IDX_W-1:0] wrIdx;

  // Flag arrives a cycle ahead of its writeback
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shortQ <= 1'b0;
    else       shortQ <= wbSoonShort;
  end

  assign accept = wbValid && !shortQ && !flush;
  assign hitOld = |wrMatch;
  assign wrIdx  = hitOld ? firstSet(wrMatch) : victimIdx;

  always_comb begin
    strobe        = '0;
    strobe.wrEn   = accept;
    strobe.clrAll = flush;
    strobe.wrIdx  = IDX_MAX_W'(wrIdx);
  end

  if (USE_LRU == 0) begin : g_fifo
    logic [IDX_W-1:0] ptrQ;
    logic             unusedSig;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  ptrQ <= '0;
      else if (flush)             ptrQ <= '0;
      else if (accept && !hitOld) ptrQ <= (ptrQ == IDX_W'(ENTRIES - 1)) ? '0 : ptrQ + 1'b1;
    end

    assign victimIdx = ptrQ;
    assign unusedSig = ^{rdMatch, validVec};
  end else begin : g_lru
    logic [IDX_W-1:0] ageQ [ENTRIES];
    logic             touch;
    logic [IDX_W-1:0] touchIdx;
    logic [IDX_W-1:0] touchAge;
    logic [IDX_W-1:0] oldIdx;

    always_comb begin
      touch    = 1'b0;
      touchIdx = '0;
      if (flush) begin
        touch = 1'b0;
      end else if (accept) begin
        touch    = 1'b1;
        touchIdx = wrIdx;
      end else begin
        for (int p = RD_PORTS - 1; p >= 0; p--) begin
          if (|rdMatch[p*ENTRIES +: ENTRIES]) begin
            touch    = 1'b1;
            touchIdx = firstSet(rdMatch[p*ENTRIES +: ENTRIES]);
          end
        end
      end
    end

    always_comb begin
      oldIdx = '0;
      for (int e = 0; e < ENTRIES; e++)
        if (ageQ[e] == IDX_W'(ENTRIES - 1)) oldIdx = IDX_W'(e);
    end

    assign touchAge  = ageQ[touchIdx];
    assign victimIdx = (&validVec) ? oldIdx : firstSet(~validVec);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_age
      logic [IDX_W-1:0] ageR;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ageR <= IDX_W'(e);
        else if (touch) begin
          if (touchIdx == IDX_W'(e)) ageR <= '0;
          else if (ageR < touchAge)  ageR <= ageR + 1'b1;
        end
      end
      assign ageQ[e] = ageR;
    end
  end
endmodule

// File: rtl/rl_operand_cache.sv
module rl_operand_cache
  import rl_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int RD_PORTS = 2,
  parameter int TAG_W    = 6,
  parameter int DATA_W   = 32,
  parameter int USE_LRU  = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       wbSoonShort,
  input  logic                       wbValid,
  input  logic [TAG_W-1:0]           wbTag,
  input  logic [DATA_W-1:0]          wbData,
  input  logic [RD_PORTS-1:0]        rdValid,
  input  logic [RD_PORTS*TAG_W-1:0]  rdTag,
  output logic [RD_PORTS-1:0]        rdHit,
  output logic [RD_PORTS*DATA_W-1:0] rdData
);
  rl_strobe_t                  strobe;
  logic [ENTRIES-1:0]          validVec;
  logic [ENTRIES-1:0]          wrMatch;
  logic [RD_PORTS*ENTRIES-1:0] rdMatch;

  rl_ctrl #(
    .ENTRIES(ENTRIES), .RD_PORTS(RD_PORTS), .USE_LRU(USE_LRU)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .wbValid(wbValid),
    .wbSoonShort(wbSoonShort), .validVec(validVec), .wrMatch(wrMatch),
    .rdMatch(rdMatch), .strobe(strobe)
  );

  rl_store #(
    .ENTRIES(ENTRIES), .RD_PORTS(RD_PORTS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrTag(wbTag), .wrData(wbData),
    .rdValid(rdValid), .rdTag(rdTag), .validVec(validVec), .wrMatch(wrMatch),
    .rdMatch(rdMatch), .rdHit(rdHit), .rdData(rdData)
  );
endmodule

// File: rtl/rl_operand_cache_chk.sv
module rl_operand_cache_chk #(
  parameter int ENTRIES  = 8,
  parameter int RD_PORTS = 2,
  parameter int TAG_W    = 6,
  parameter int DATA_W   = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        flush,
  input logic                        wbSoonShort,
  input logic                        wbValid,
  input logic [TAG_W-1:0]            wbTag,
  input logic [DATA_W-1:0]           wbData,
  input logic [RD_PORTS-1:0]         rdValid,
  input logic [RD_PORTS*TAG_W-1:0]   rdTag,
  input logic [RD_PORTS-1:0]         rdHit,
  input logic [RD_PORTS*DATA_W-1:0]  rdData,
  input logic [ENTRIES-1:0]          validVec,
  input logic [RD_PORTS*ENTRIES-1:0] rdMatch,
  input logic                        accept
);
  logic [TAG_W-1:0]  tag0;
  logic [DATA_W-1:0] data0;
  assign tag0  = rdTag[TAG_W-1:0];
  assign data0 = rdData[DATA_W-1:0];

  a_r1_fill_grows: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> ($countones(validVec) >= $past($countones(validVec))));

  a_r2_written_then_found: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accept) && rdValid[0] && (tag0 == $past(wbTag)) && !(accept && (wbTag == tag0)))
      |-> (rdHit[0] && (data0 == $past(wbData))));

  a_r4_short_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wbSoonShort) && wbValid && !flush) |=> $stable(validVec));

  a_r5_same_cycle_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (accept && rdValid[0] && (tag0 == wbTag)) |-> (rdHit[0] && (data0 == wbData)));

  a_r6_single_copy: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdMatch[ENTRIES-1:0]));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validVec == '0));

  a_r10_idle_port_misses: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid[0] |-> !rdHit[0]);
endmodule

bind rl_operand_cache rl_operand_cache_chk #(
  .ENTRIES(ENTRIES), .RD_PORTS(RD_PORTS), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .wbSoonShort(wbSoonShort),
  .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData), .rdValid(rdValid),
  .rdTag(rdTag), .rdHit(rdHit), .rdData(rdData), .validVec(validVec),
  .rdMatch(rdMatch), .accept(strobe.wrEn)
);

// File: tb/sim_rl_operand_cache.sv
module sim_rl_operand_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int P  = 2;
  localparam int TW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic wbSoonShort = 1'b0;
  logic wbValid = 1'b0;
  logic [TW-1:0] wbTag = '0;
  logic [DW-1:0] wbData = '0;
  logic [P-1:0] rdValid = '0;
  logic [P*TW-1:0] rdTag = '0;
  logic [P-1:0] hitF, hitL;
  logic [P*DW-1:0] dataF, dataL;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rl_operand_cache #(.ENTRIES(N), .RD_PORTS(P), .TAG_W(TW), .DATA_W(DW), .USE_LRU(0)) u0 (
    .clk(clk), .rstN(rstN), .flush(flush), .wbSoonShort(wbSoonShort), .wbValid(wbValid),
    .wbTag(wbTag), .wbData(wbData), .rdValid(rdValid), .rdTag(rdTag),
    .rdHit(hitF), .rdData(dataF));

  rl_operand_cache #(.ENTRIES(N), .RD_PORTS(P), .TAG_W(TW), .DATA_W(DW), .USE_LRU(1)) u1 (
    .clk(clk), .rstN(rstN), .flush(flush), .wbSoonShort(wbSoonShort), .wbValid(wbValid),
    .wbTag(wbTag), .wbData(wbData), .rdValid(rdValid), .rdTag(rdTag),
    .rdHit(hitL), .rdData(dataL));

  // Reference model, index 0 = FIFO, 1 = LRU
  bit            mV [2][N];
  logic [TW-1:0] mT [2][N];
  logic [DW-1:0] mD [2][N];
  int            mS [2][N];
  int            mPtr [2];
  int            mCnt = 0;
  bit            mShort = 1'b0;

  function automatic void mLook(input int pol, input bit v, input logic [TW-1:0] t,
                                output bit h, output logic [DW-1:0] d);
    bit acc;
    acc = wbValid && !mShort && !flush;
    h = 1'b0;
    d = '0;
    if (!v) return;
    if (acc && (t == wbTag)) begin
      h = 1'b1;
      d = wbData;
      return;
    end
    for (int i = 0; i < N; i++)
      if (mV[pol][i] && mT[pol][i] == t) begin
        h = 1'b1;
        d = mD[pol][i];
      end
  endfunction

  function automatic void mUpdate();
    bit acc;
    acc = wbValid && !mShort && !flush;
    for (int pol = 0; pol < 2; pol++) begin
      if (flush) begin
        for (int i = 0; i < N; i++) mV[pol][i] = 1'b0;
        mPtr[pol] = 0;
      end else if (acc) begin
        int k;
        k = -1;
        for (int i = 0; i < N; i++) if (k < 0 && mV[pol][i] && mT[pol][i] == wbTag) k = i;
        if (k < 0) begin
          if (pol == 0) begin
            k = mPtr[0];
            mPtr[0] = (mPtr[0] + 1) % N;
          end else begin
            for (int i = 0; i < N; i++) if (k < 0 && !mV[pol][i]) k = i;
            if (k < 0) begin
              k = 0;
              for (int i = 1; i < N; i++) if (mS[pol][i] < mS[pol][k]) k = i;
            end
          end
        end
        mV[pol][k] = 1'b1;
        mT[pol][k] = wbTag;
        mD[pol][k] = wbData;
        mCnt++;
        mS[pol][k] = mCnt;
      end else if (pol == 1) begin
        bit touched;
        touched = 1'b0;
        for (int p = 0; p < P; p++)
          for (int i = 0; i < N; i++)
            if (!touched && rdValid[p] && mV[1][i] && mT[1][i] == rdTag[p*TW +: TW]) begin
              touched = 1'b1;
              mCnt++;
              mS[1][i] = mCnt;
            end
      end
    end
    mShort = wbSoonShort;
  endfunction

  task automatic step(input bit wv, input logic [TW-1:0] wt, input logic [DW-1:0] wd,
                      input bit soon, input bit fl, input bit v0, input logic [TW-1:0] t0,
                      input bit v1, input logic [TW-1:0] t1, input string req);
    @(negedge clk);
    wbValid = wv; wbTag = wt; wbData = wd; wbSoonShort = soon; flush = fl;
    rdValid = {v1, v0}; rdTag = {t1, t0};
    #1;
    for (int pol = 0; pol < 2; pol++) begin
      for (int p = 0; p < P; p++) begin
        bit eh;
        logic [DW-1:0] ed;
        bit ah;
        logic [DW-1:0] ad;
        mLook(pol, rdValid[p], rdTag[p*TW +: TW], eh, ed);
        ah = (pol == 0) ? hitF[p] : hitL[p];
        ad = (pol == 0) ? dataF[p*DW +: DW] : dataL[p*DW +: DW];
        checks++;
        if (ah !== eh || ad !== ed) begin
          fails++;
          $display("FAIL %s policy%0d port%0d hit/data actual %0d/%h expected %0d/%h",
                   req, pol, p, ah, ad, eh, ed);
        end
      end
    end
    mUpdate();
  endtask

  task automatic wr(input logic [TW-1:0] t, input logic [DW-1:0] d, input string req);
    step(1'b1, t, d, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic look(input logic [TW-1:0] t0, input logic [TW-1:0] t1, input string req);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, t0, 1'b1, t1, req);
  endtask

  task automatic sweep(input string req);
    for (int t = 0; t < 32; t += 2) look(TW'(t), TW'(t + 1), req);
  endtask

  initial begin
    void'($urandom(32'd20031));
    for (int pol = 0; pol < 2; pol++) begin
      mPtr[pol] = 0;
      for (int i = 0; i < N; i++) begin
        mV[pol][i] = 1'b0; mT[pol][i] = '0; mD[pol][i] = '0; mS[pol][i] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R2: empty after reset, every lookup misses
    look(6'd0, 6'd5, "R2_reset");

    // R1: fill to capacity, all present
    for (int i = 1; i <= N; i++) wr(TW'(i), 32'hA000_0000 + i, "R1_fill");
    sweep("R1_all_hit");

    // R10: idle port reports miss even for a stored tag
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 6'd3, 1'b0, 6'd4, "R10_idle");

    // R9: touch tag 1 so LRU spares it; R8: FIFO still evicts tag 1
    look(6'd1, 6'd40, "R9_touch");
    wr(6'd9, 32'hB9, "R8_evict");
    sweep("R8_R9_survivors");

    // R4 / R3: short-lived write dropped, replacement unchanged
    step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R3_flag");
    step(1'b1, 6'd20, 32'hC20, 1'b0, 1'b0, 1'b1, 6'd20, 1'b1, 6'd2, "R4_short_write");
    look(6'd20, 6'd9, "R4_not_stored");
    wr(6'd21, 32'hC21, "R4_next_alloc");
    sweep("R4_order_kept");

    // R3: flag in the same cycle as the write does not block it
    step(1'b1, 6'd22, 32'hC22, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R3_same_cycle");
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 6'd22, 1'b1, 6'd21, "R3_stored");

    // R5: same-cycle write and lookup
    step(1'b1, 6'd30, 32'hD30, 1'b0, 1'b0, 1'b1, 6'd30, 1'b1, 6'd30, "R5_bypass_new");
    step(1'b1, 6'd30, 32'hE30, 1'b0, 1'b0, 1'b1, 6'd30, 1'b0, '0, "R5_bypass_update");

    // R6: in-place update, no extra allocation
    wr(6'd22, 32'hF22, "R6_update");
    wr(6'd22, 32'hF23, "R6_update");
    wr(6'd31, 32'hF31, "R6_alloc_after");
    sweep("R6_contents");

    // R7: flush drops same-cycle write, array refills from slot 0
    step(1'b1, 6'd11, 32'h1111, 1'b0, 1'b1, 1'b1, 6'd30, 1'b1, 6'd22, "R7_flush");
    sweep("R7_empty");
    for (int i = 0; i < N + 2; i++) wr(TW'(40 + i), 32'h4000 + i, "R7_refill");
    for (int t = 38; t < 52; t += 2) look(TW'(t), TW'(t + 1), "R7_R8_R9_refill");

    // R2: random traffic with a small tag space
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 3) != 0, TW'($urandom_range(0, 15)), $urandom,
           $urandom_range(0, 2) == 0, $urandom_range(0, 99) == 0,
           $urandom_range(0, 3) != 0, TW'($urandom_range(0, 15)),
           $urandom_range(0, 3) != 0, TW'($urandom_range(0, 15)), "R2_random");
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule